// File: doc/BRIEF.md
# Predicated Vector Float-to-Integer Truncating Converter

This block turns every active floating-point lane of a 64-bit vector slice into a signed integer. The fractional part is always dropped, so each result rounds toward zero. A three-bit size code chooses the source format (half, single or double precision) and the integer width (16, 32 or 64 bits). Each lane lives in a container as wide as the wider of those two widths. A narrow source is read from the low end of its container. A narrow result is sign-extended to fill its container.

An eight-bit predicate, one bit per byte, selects which containers are converted. A mode bit decides what an unselected container holds: the old destination bits (merging) or zero (zeroing). Values outside the integer range saturate and raise an invalid flag. A NaN yields zero and also raises the flag. The result, the valid strobe and the flag are registered one clock after an input strobe.

Top module: `vec_ftoi_trunc`

## Requirements
- R1: `outValid` is high in exactly the cycle after a cycle with `inValid` high. While `inValid` is low, `outResult` and `outInvalid` keep their values.
- R2: Size codes for `sizeSel`, given as source→integer (container): 0 half→16 (four 16-bit lanes), 1 half→32 (two 32-bit lanes), 2 half→64 (one lane), 3 single→32 (two 32-bit lanes), 4 single→64 (one lane), 5 double→32 (one 64-bit lane), 6 double→64 (one lane). Lane k occupies bits starting at k times the container width.
- R3: Every in-range finite value converts to its integer part, truncated toward zero (1.5→1, −2.75→−2).
- R4: When the source is narrower than its container, only the low source-width bits of the container are read. The upper bits have no effect.
- R5: When the integer is narrower than its container, the result is sign-extended over the whole container.
- R6: A container is active when the predicate bit of its lowest byte (bit index = first byte number) is set. Its other predicate bits are ignored.
- R7: With `zeroMode` low, an inactive container keeps the bits of `oldDst`.
- R8: With `zeroMode` high, an inactive container is written as zero.
- R9: A value whose truncated integer lies above the maximum or below the minimum of the integer width gives that maximum or minimum and raises `outInvalid`. A value whose truncation is exactly the minimum gives no flag.
- R10: A NaN gives zero and raises `outInvalid`. +∞ and −∞ give the maximum and minimum and raise `outInvalid`.
- R11: Zero, subnormal values and values of magnitude below one give zero, with no flag.
- R12: `outInvalid` is the OR of the flag conditions of active containers only.
- R13: Size code 7 is reserved: no container is active and no flag is raised.
- R14: While `rstN` is low, `outValid`, `outResult` and `outInvalid` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Input strobe |
| sizeSel | input | 3 | Source/integer size code |
| zeroMode | input | 1 | 1 = zeroing, 0 = merging for inactive containers |
| pred | input | 8 | Byte-granular predicate |
| srcVec | input | 64 | Floating-point source slice |
| oldDst | input | 64 | Previous destination contents |
| outValid | output | 1 | Result strobe |
| outResult | output | 64 | Converted slice |
| outInvalid | output | 1 | Invalid-operation flag over active lanes |

## Verification
Within one slice, a lane that saturates or carries a NaN can sit beside a lane that predication merges or zeroes. The flag must then reflect only the active lanes. The bench provokes this by placing NaNs and out-of-range values in inactive containers next to converting lanes, and also in active ones. A behavioural real-number model, updated every clock, judges both the result bits and the flag. The same applies when a narrow result's sign extension and a merged neighbour share the slice.

// File: rtl/vft_pkg.sv
package vft_pkg;
  typedef enum logic [1:0] {FMT_H, FMT_S, FMT_D} srcFmt_e;
  typedef enum logic [1:0] {DW16, DW32, DW64} dstW_e;
  typedef enum logic [1:0] {CT16, CT32, CT64} cont_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     load;
    logic     zeroFill;
    logic     anyLane;
    srcFmt_e  srcFmt;
    dstW_e    dstW;
    cont_e    cont;
  } cvtStrobe_t;
endpackage

// File: rtl/vft_lane.sv
// One scalar truncating converter; result always sign-extended to 64 bits.
module vft_lane
  import vft_pkg::*;
(
  input  logic [63:0] opnd,
  input  srcFmt_e     fmt,
  input  dstW_e       dw,
  output logic [63:0] val,
  output logic        inv
);
  localparam int MANT_W = 53;

  logic               sgn;
  logic [10:0]        expField;
  logic [10:0]        expOnes;
  logic [51:0]        frac;
  logic signed [12:0] biasS;
  logic signed [12:0] unb;
  logic               expMax, expZero, fracZero;
  logic [63:0]        mant, mag, maxPos, minMag;
  logic [5:0]         lim, shR, shL;

  always_comb begin
    // R4: narrow formats read only the low bits of the operand
    case (fmt)
      FMT_H: begin
        sgn = opnd[15]; expField = {6'b0, opnd[14:10]}; expOnes = 11'h01f;
        frac = {opnd[9:0], 42'b0}; biasS = 13'sd15;
      end
      FMT_S: begin
        sgn = opnd[31]; expField = {3'b0, opnd[30:23]}; expOnes = 11'h0ff;
        frac = {opnd[22:0], 29'b0}; biasS = 13'sd127;
      end
      default: begin
        sgn = opnd[63]; expField = opnd[62:52]; expOnes = 11'h7ff;
        frac = opnd[51:0]; biasS = 13'sd1023;
      end
    endcase
    expMax   = (expField == expOnes);
    expZero  = (expField == 11'd0);
    fracZero = (frac == 52'd0);
    unb      = signed'({2'b00, expField}) - biasS;
    mant     = {{(64-MANT_W){1'b0}}, ~expZero, frac};
    case (dw)
      DW16:    lim = 6'd15;
      DW32:    lim = 6'd31;
      default: lim = 6'd63;
    endcase
    maxPos = (64'd1 << lim) - 64'd1;
    minMag = maxPos + 64'd1;
    shR = 6'd0;
    shL = 6'd0;
    if (unb >= 13'sd0 && unb <= 13'sd52) shR = 6'(13'sd52 - unb);
    else if (unb > 13'sd52 && unb <= 13'sd63) shL = 6'(unb - 13'sd52);
    mag = (mant >> shR) << shL;   // R3: fraction bits drop out
    val = 64'd0;
    inv = 1'b0;
    if (expMax && !fracZero) begin
      inv = 1'b1;                                 // R10 NaN
    end else if (expMax) begin
      inv = 1'b1;                                 // R10 infinity
      val = sgn ? ~maxPos : maxPos;
    end else if (unb < 13'sd0) begin
      val = 64'd0;                                // R11
    end else if (unb > signed'({7'b0, lim})) begin
      inv = 1'b1;                                 // R9
      val = sgn ? ~maxPos : maxPos;
    end else if (unb == signed'({7'b0, lim})) begin
      if (sgn && mag == minMag) val = ~maxPos;    // R9 exact minimum
      else begin
        inv = 1'b1;
        val = sgn ? ~maxPos : maxPos;
      end
    end else begin
      val = sgn ? (64'd0 - mag) : mag;
    end
  end
endmodule

// File: rtl/vft_ctrl.sv
// Decodes the size code into strobes and carries the valid pipeline stage.
module vft_ctrl
  import vft_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [2:0] sizeSel,
  input  logic       zeroMode,
  output cvtStrobe_t strobe,
  output logic       outValid
);
  always_comb begin
    strobe.load     = inValid;
    strobe.zeroFill = zeroMode;
    strobe.anyLane  = 1'b1;
    // R2 size code table
    case (sizeSel)
      3'd0: begin strobe.srcFmt = FMT_H; strobe.dstW = DW16; strobe.cont = CT16; end
      3'd1: begin strobe.srcFmt = FMT_H; strobe.dstW = DW32; strobe.cont = CT32; end
      3'd2: begin strobe.srcFmt = FMT_H; strobe.dstW = DW64; strobe.cont = CT64; end
      3'd3: begin strobe.srcFmt = FMT_S; strobe.dstW = DW32; strobe.cont = CT32; end
      3'd4: begin strobe.srcFmt = FMT_S; strobe.dstW = DW64; strobe.cont = CT64; end
      3'd5: begin strobe.srcFmt = FMT_D; strobe.dstW = DW32; strobe.cont = CT64; end
      3'd6: begin strobe.srcFmt = FMT_D; strobe.dstW = DW64; strobe.cont = CT64; end
      default: begin   // R13 reserved code
        strobe.srcFmt = FMT_D; strobe.dstW = DW64; strobe.cont = CT64;
        strobe.anyLane = 1'b0;
      end
    endcase
  end

  // R1, R14
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end
endmodule

// File: rtl/vft_dp.sv
// Lane steering, predication and the result register.
module vft_dp
  import vft_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  cvtStrobe_t        strobe,
  input  logic [DATA_W/8-1:0] pred,
  input  logic [DATA_W-1:0] srcVec,
  input  logic [DATA_W-1:0] oldDst,
  output logic [DATA_W-1:0] outResult,
  output logic              outInvalid
);
  localparam int N16 = DATA_W / 16;
  localparam int N32 = DATA_W / 32;
  localparam int N64 = DATA_W / 64;
  localparam int NL  = N16;

  logic [63:0]       laneOp  [NL];
  logic [63:0]       laneVal [NL];
  logic [NL-1:0]     laneInv;
  logic [NL-1:0]     laneOn;
  logic [DATA_W-1:0] nextRes;
  logic              nextInv;

  // operand steering and lane activity (R4, R6, R13)
  always_comb begin
    for (int k = 0; k < NL; k++) laneOp[k] = 64'd0;
    laneOn = '0;
    case (strobe.cont)
      CT16: for (int k = 0; k < N16; k++) begin
        laneOp[k] = 64'(srcVec[16*k +: 16]);
        laneOn[k] = pred[2*k];
      end
      CT32: for (int k = 0; k < N32; k++) begin
        laneOp[k] = 64'(srcVec[32*k +: 32]);
        laneOn[k] = pred[4*k];
      end
      default: for (int k = 0; k < N64; k++) begin
        laneOp[k] = srcVec[64*k +: 64];
        laneOn[k] = pred[8*k];
      end
    endcase
    if (!strobe.anyLane) laneOn = '0;
  end

  for (genvar g = 0; g < NL; g++) begin : g_lane
    vft_lane u_lane (
      .opnd (laneOp[g]),
      .fmt  (strobe.srcFmt),
      .dw   (strobe.dstW),
      .val  (laneVal[g]),
      .inv  (laneInv[g])
    );
  end

  // result assembly (R5, R7, R8, R12)
  always_comb begin
    nextRes = strobe.zeroFill ? '0 : oldDst;
    case (strobe.cont)
      CT16: for (int k = 0; k < N16; k++)
        if (laneOn[k]) nextRes[16*k +: 16] = laneVal[k][15:0];
      CT32: for (int k = 0; k < N32; k++)
        if (laneOn[k]) nextRes[32*k +: 32] = laneVal[k][31:0];
      default: for (int k = 0; k < N64; k++)
        if (laneOn[k]) nextRes[64*k +: 64] = laneVal[k];
    endcase
    nextInv = |(laneOn & laneInv);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outResult  <= '0;
      outInvalid <= 1'b0;
    end else if (strobe.load) begin
      outResult  <= nextRes;
      outInvalid <= nextInv;
    end
  end
endmodule

// File: rtl/vec_ftoi_trunc.sv
module vec_ftoi_trunc
  import vft_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic [2:0]          sizeSel,
  input  logic                zeroMode,
  input  logic [DATA_W/8-1:0] pred,
  input  logic [DATA_W-1:0]   srcVec,
  input  logic [DATA_W-1:0]   oldDst,
  output logic                outValid,
  output logic [DATA_W-1:0]   outResult,
  output logic                outInvalid
);
  cvtStrobe_t strobe;

  vft_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .sizeSel  (sizeSel),
    .zeroMode (zeroMode),
    .strobe   (strobe),
    .outValid (outValid)
  );

  vft_dp #(.DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .pred       (pred),
    .srcVec     (srcVec),
    .oldDst     (oldDst),
    .outResult  (outResult),
    .outInvalid (outInvalid)
  );
endmodule

// File: rtl/vft_checker.sv
module vft_checker #(
  parameter int DATA_W = 64
) (
  input logic                clk,
  input logic                rstN,
  input logic                inValid,
  input logic [2:0]          sizeSel,
  input logic                zeroMode,
  input logic [DATA_W/8-1:0] pred,
  input logic [DATA_W-1:0]   oldDst,
  input logic                outValid,
  input logic [DATA_W-1:0]   outResult,
  input logic                outInvalid
);
  p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!outValid && $stable(outResult) && $stable(outInvalid)));

  p_merge_inactive_r7: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !zeroMode && pred == '0) |=> (outResult == $past(oldDst) && !outInvalid));

  p_zero_inactive_r8: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && zeroMode && pred == '0) |=> (outResult == '0 && !outInvalid));

  p_reserved_quiet_r13: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && sizeSel == 3'd7) |=> !outInvalid);

  p_sign_ext_r5: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && sizeSel == 3'd5 && pred[0]) |=> (outResult[63:32] == {32{outResult[31]}}));
endmodule

bind vec_ftoi_trunc vft_checker #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .inValid    (inValid),
  .sizeSel    (sizeSel),
  .zeroMode   (zeroMode),
  .pred       (pred),
  .oldDst     (oldDst),
  .outValid   (outValid),
  .outResult  (outResult),
  .outInvalid (outInvalid)
);

// File: tb/vec_ftoi_trunc_tb.sv
module vec_ftoi_trunc_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [2:0]  sizeSel = 3'd0;
  logic        zeroMode = 1'b0;
  logic [7:0]  pred = 8'h00;
  logic [63:0] srcVec = 64'd0;
  logic [63:0] oldDst = 64'd0;
  logic        outValid;
  logic [63:0] outResult;
  logic        outInvalid;

  int    nChecks = 0;
  int    nFails  = 0;
  bit    done    = 1'b0;
  string curTag  = "R14";

  // behavioural model state
  logic        mValid = 1'b0;
  logic [63:0] mRes   = 64'd0;
  logic        mInv   = 1'b0;
  string       mTag   = "R14";

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_ftoi_trunc u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .sizeSel(sizeSel),
    .zeroMode(zeroMode), .pred(pred), .srcVec(srcVec), .oldDst(oldDst),
    .outValid(outValid), .outResult(outResult), .outInvalid(outInvalid)
  );

  function automatic longint truncPos(real x);
    longint l;
    l = longint'(x);
    if (real'(l) > x) l = l - 1;
    return l;
  endfunction

  // scalar model: real value, then integer part with saturation
  function automatic void refElem(input logic [63:0] c, input int sb, input int w,
                                  output logic [63:0] v, output bit bad);
    real x, lim;
    bit nan, inf, neg;
    longint e, f, mx, mn;
    if (sb == 16) begin
      neg = c[15]; e = longint'(c[14:10]); f = longint'(c[9:0]);
      nan = (e == 31) && (f != 0); inf = (e == 31) && (f == 0);
      x = (e == 0) ? f * 2.0**(-24) : (1.0 + f / 1024.0) * 2.0**(e - 15);
    end else if (sb == 32) begin
      neg = c[31]; e = longint'(c[30:23]); f = longint'(c[22:0]);
      nan = (e == 255) && (f != 0); inf = (e == 255) && (f == 0);
      x = (e == 0) ? f * 2.0**(-149) : (1.0 + f / 8388608.0) * 2.0**(e - 127);
    end else begin
      neg = c[63]; e = longint'(c[62:52]); f = longint'(c[51:0]);
      nan = (e == 2047) && (f != 0); inf = (e == 2047) && (f == 0);
      x = $bitstoreal({1'b0, c[62:0]});
    end
    if (w == 64) mx = 64'h7fff_ffff_ffff_ffff;
    else         mx = (longint'(1) <<< (w - 1)) - 1;
    mn  = -mx - 1;
    lim = 2.0**(w - 1);
    bad = 1'b0;
    v   = 64'd0;
    if (nan) bad = 1'b1;
    else if (inf) begin bad = 1'b1; v = neg ? mn : mx; end
    else if (!neg) begin
      if (x >= lim) begin bad = 1'b1; v = mx; end
      else v = truncPos(x);
    end else begin
      if ((w == 64 && x > lim) || (w < 64 && x >= lim + 1.0)) begin bad = 1'b1; v = mn; end
      else if (x >= lim) v = mn;
      else v = -truncPos(x);
    end
  endfunction

  function automatic void refSlice(input logic [2:0] sel, input logic zm, input logic [7:0] pr,
                                   input logic [63:0] src, input logic [63:0] old,
                                   output logic [63:0] res, output logic inv);
    int sb, w, cw;
    logic [63:0] c, v;
    bit bad;
    res = zm ? 64'd0 : old;
    inv = 1'b0;
    case (sel)
      3'd0: begin sb = 16; w = 16; cw = 16; end
      3'd1: begin sb = 16; w = 32; cw = 32; end
      3'd2: begin sb = 16; w = 64; cw = 64; end
      3'd3: begin sb = 32; w = 32; cw = 32; end
      3'd4: begin sb = 32; w = 64; cw = 64; end
      3'd5: begin sb = 64; w = 32; cw = 64; end
      3'd6: begin sb = 64; w = 64; cw = 64; end
      default: return;
    endcase
    for (int k = 0; k < 64 / cw; k++) begin
      if (pr[k * cw / 8]) begin
        c = src >> (k * cw);
        if (cw < 64) c = c & ((64'd1 << cw) - 64'd1);
        refElem(c, sb, w, v, bad);
        for (int b = 0; b < cw; b++) res[k * cw + b] = v[b];
        inv = inv | bad;
      end
    end
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mValid = 1'b0; mRes = 64'd0; mInv = 1'b0; mTag = "R14";
    end else begin
      mValid = inValid;
      if (inValid) begin
        refSlice(sizeSel, zeroMode, pred, srcVec, oldDst, mRes, mInv);
        mTag = curTag;
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      nChecks++;
      if (outValid !== mValid) begin
        nFails++;
        $display("FAIL R1 outValid actual=%0b expected=%0b", outValid, mValid);
      end
      if (outResult !== mRes || outInvalid !== mInv) begin
        nFails++;
        $display("FAIL %s result actual=%h/%0b expected=%h/%0b",
                 mTag, outResult, outInvalid, mRes, mInv);
      end
    end
  end

  task automatic send(input logic [2:0] sel, input logic zm, input logic [7:0] pr,
                      input logic [63:0] src, input logic [63:0] old, input string tag);
    @(negedge clk);
    inValid = 1'b1; sizeSel = sel; zeroMode = zm; pred = pr;
    srcVec = src; oldDst = old; curTag = tag;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0;
      srcVec = 64'hFFFF_0000_FFFF_0000; curTag = "R1 hold";
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);   // R14 checked while in reset
    rstN = 1'b1;
    idle(2);
    // R2 R3: half to 16, 1.5 -2.75 100.875 -0.0
    send(3'd0, 1'b0, 8'hFF, 64'h8000_564E_C180_3E00, 64'h1111_2222_3333_4444, "R2 R3");
    // R4: junk in upper halves of 32-bit containers
    send(3'd1, 1'b0, 8'hFF, 64'hDEAD_3E00_BEEF_C180, 64'd0, "R4");
    idle(1);
    // R5: narrow negative results sign-extended
    send(3'd2, 1'b1, 8'h01, 64'hFFFF_FFFF_FFFF_C180, 64'd0, "R5 half->64");
    send(3'd5, 1'b1, 8'h01, 64'hC1E0_0000_0010_0000, 64'd0, "R5 R9 double->32 min");
    // R6: only non-lowest bytes set, then lowest only
    send(3'd1, 1'b0, 8'hEE, 64'h3E00_3E00_3E00_3E00, 64'hAAAA_BBBB_CCCC_DDDD, "R6 R7");
    send(3'd1, 1'b0, 8'h11, 64'h3E00_3E00_3E00_3E00, 64'hAAAA_BBBB_CCCC_DDDD, "R6");
    // R7 R8: mixed predicate in both modes
    send(3'd0, 1'b0, 8'h05, 64'h564E_564E_564E_564E, 64'h0123_4567_89AB_CDEF, "R7");
    send(3'd0, 1'b1, 8'h05, 64'h564E_564E_564E_564E, 64'h0123_4567_89AB_CDEF, "R8");
    send(3'd3, 1'b1, 8'h00, 64'h7FC0_0000_7FC0_0000, 64'hFFFF_FFFF_FFFF_FFFF, "R8 R12");
    // R9: saturation and exact minimum
    send(3'd0, 1'b0, 8'hFF, 64'h7800_F800_F8E2_78E2, 64'd0, "R9 half->16");
    send(3'd0, 1'b0, 8'h10, 64'h7800_F800_F8E2_78E2, 64'd0, "R9 exact min");
    send(3'd3, 1'b0, 8'h11, 64'hCF32_D05E_4F32_D05E, 64'd0, "R9 single->32");
    send(3'd6, 1'b0, 8'h01, 64'h43E1_58E4_6091_3D00, 64'd0, "R9 double->64");
    send(3'd6, 1'b0, 8'h01, 64'hC3E0_0000_0000_0000, 64'd0, "R9 -2^63");
    send(3'd5, 1'b0, 8'h01, 64'h41E0_0000_0000_0000, 64'd0, "R9 2^31");
    // R10: NaN and infinities
    send(3'd6, 1'b0, 8'h01, 64'h7FF8_0000_0000_0000, 64'h5555, "R10 NaN");
    send(3'd4, 1'b0, 8'h01, 64'h0000_0000_7F80_0000, 64'd0, "R10 +inf");
    send(3'd5, 1'b0, 8'h01, 64'hFFF0_0000_0000_0000, 64'd0, "R10 -inf");
    send(3'd0, 1'b0, 8'hFF, 64'hFC00_7C00_7E00_3E00, 64'd0, "R10 half lanes");
    // R11: zero, subnormal, below one
    send(3'd0, 1'b0, 8'hFF, 64'h0000_8001_0001_3BEB, 64'hFFFF_FFFF_FFFF_FFFF, "R11 half");
    send(3'd3, 1'b0, 8'hFF, 64'h8000_0001_3F7F_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, "R11 single");
    // R12: bad values only in inactive containers
    send(3'd0, 1'b0, 8'h01, 64'h7E00_7C00_FC00_3E00, 64'd0, "R12");
    send(3'd6, 1'b0, 8'hFE, 64'h7FF8_0000_0000_0000, 64'h77, "R12 inactive NaN");
    // R13: reserved code
    send(3'd7, 1'b0, 8'hFF, 64'h7FF8_0000_0000_0000, 64'h9999, "R13 merge");
    send(3'd7, 1'b1, 8'hFF, 64'h7FF8_0000_0000_0000, 64'h9999, "R13 zero");
    idle(3);
    // mixed random traffic
    for (int i = 0; i < 400; i++) begin
      logic [63:0] s;
      s = {$urandom, $urandom};
      if (i % 3 == 0) s[62:52] = 11'd1000 + 11'($urandom % 70);
      if (i % 4 == 1) s[14:10] = 5'd12 + 5'($urandom % 8);
      send(3'($urandom % 8), 1'($urandom), 8'($urandom), s, {$urandom, $urandom},
           "R2 R3 R6 R7 R8 R12 random");
      if (i % 7 == 0) idle(1);
    end
    idle(3);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end
endmodule